// File: doc/BRIEF.md
# Paged I2C Register Target

This block is an I2C target that gives a host access to an internal register space wider than the 8-bit byte offset that I2C carries. The space is split into 256-byte pages. One byte offset, 0xFF, is the page selector in every page. A write to it loads an internal page register and does not reach the register bus. Every other offset is combined with the current page to form a 16-bit internal address, {page, offset}.

A host transaction starts with the target address and a write bit. The first byte after that is the byte offset and any later bytes are data. Each data byte moves the offset pointer on by one, so a 16-bit value sent most significant byte first lands at two consecutive offsets. To read, the host writes the offset alone, issues a repeated start with the read bit, and clocks out consecutive registers until it answers with a NACK. Inside the chip the block drives a simple register bus: page, offset, write data, a one-cycle write strobe and a one-cycle read strobe. Read data is returned one clock after the read strobe.

SCL and SDA are sampled with the system clock. The SDA output is an open-drain enable. Each SCL half period must last at least 8 system clocks.

Top module: `paged_i2c_target`

## Requirements
- R1: A data byte written at pointer X while the page register holds P produces one `reg_wr` pulse, with `reg_page`=P, `reg_offset`=X and `reg_wdata` equal to the byte. The pulse is exactly one clock long.
- R2: The first byte after a write address sets the pointer. The pointer then advances by one after every data byte, written or read. It wraps from 0xFF to 0x00 and never changes the page.
- R3: A data byte written while the pointer is 0xFF loads the page register and produces no `reg_wr`. The next data byte of the same transaction goes to offset 0x00 of the new page.
- R4: The page register resets to 0 and keeps its value across transactions until it is written again.
- R5: After a write of the offset alone and a repeated start with the read bit, each byte read returns the register at the pointer, most significant bit first. Consecutive bytes come from consecutive offsets.
- R6: Offset 0xFF, and any page at or above `NUM_PAGES`, is unimplemented. Reads there return 0x00 without a `reg_rd` pulse. Writes there are acknowledged but produce no `reg_wr` (except the page load of R3).
- R7: A transaction whose 7-bit address differs from `TARGET_ADDR` is not acknowledged, and its bytes cause no strobe.
- R8: Every address-matched write byte is acknowledged. A NACK from the host ends a read, and the target leaves SDA released until the next start.
- R9: `sda_oe` is asserted only while SCL is low.
- R10: After reset, `sda_oe`, `reg_wr` and `reg_rd` are 0, and `reg_page` and `reg_offset` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_page | output | 8 | Current page (upper address byte) |
| reg_offset | output | 8 | Current offset (lower address byte) |
| reg_wdata | output | 8 | Write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |

## Verification
Some properties are checked on every cycle:
- strobes are single-cycle and mutually exclusive;
- no strobe targets offset 0xFF or a page outside the implemented range;
- after each write strobe the offset steps by one with the page held;
- SDA is only ever grabbed while SCL is low.

Other behaviour can only be shown by the bench's host scenarios:
- a page change taking effect in the middle of a transaction;
- the page persisting between transactions;
- burst reads wrapping across the page selector;
- zero data from unimplemented space;
- a foreign address being ignored;
- the target going quiet after a NACK.

// File: rtl/paged_i2c_pkg.sv
package paged_i2c_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] i2c_byte_t;

  typedef enum logic [2:0] {
    TS_IDLE,
    TS_ADDR,
    TS_ADDR_ACK,
    TS_WBYTE,
    TS_WACK,
    TS_RBYTE,
    TS_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;
  localparam int L_SCL = 1;
  localparam int L_SDA = 0;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] cur;
  logic [LINES-1:0] prv_q;
  logic [STAGES-1:0] chain_q [LINES];

  assign raw = {scl_i, sda_i};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q[l] <= '1;
        prv_q[l]   <= 1'b1;
      end else begin
        chain_q[l] <= {chain_q[l][STAGES-2:0], raw[l]};
        prv_q[l]   <= chain_q[l][STAGES-1];
      end
    end
    assign cur[l] = chain_q[l][STAGES-1];
  end

  assign sda_s     = cur[L_SDA];
  assign scl_rise  = cur[L_SCL] & ~prv_q[L_SCL];
  assign scl_fall  = ~cur[L_SCL] & prv_q[L_SCL];
  assign start_det = cur[L_SCL] & prv_q[L_SCL] & prv_q[L_SDA] & ~cur[L_SDA];
  assign stop_det  = cur[L_SCL] & prv_q[L_SCL] & ~prv_q[L_SDA] & cur[L_SDA];
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import paged_i2c_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h70
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      scl_rise,
  input  logic      scl_fall,
  input  logic      start_det,
  input  logic      stop_det,
  input  logic      sda_s,
  input  i2c_byte_t tx_byte,
  output logic      sda_oe,
  output logic      wb_valid,
  output i2c_byte_t wb_data,
  output logic      wb_is_offset,
  output logic      rd_first,
  output logic      rd_next,
  output logic      rd_ack
);
  tgt_state_e state_q;
  logic [3:0] cnt_q;
  i2c_byte_t  sh_q;
  i2c_byte_t  txs_q;
  logic       rw_q;
  logic       first_q;
  logic       nack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= TS_IDLE;
      cnt_q        <= '0;
      sh_q         <= '0;
      txs_q        <= '0;
      rw_q         <= 1'b0;
      first_q      <= 1'b0;
      nack_q       <= 1'b0;
      sda_oe       <= 1'b0;
      wb_valid     <= 1'b0;
      wb_data      <= '0;
      wb_is_offset <= 1'b0;
      rd_first     <= 1'b0;
      rd_next      <= 1'b0;
      rd_ack       <= 1'b0;
    end else begin
      wb_valid <= 1'b0;
      rd_first <= 1'b0;
      rd_next  <= 1'b0;
      if (start_det) begin
        state_q <= TS_ADDR;
        cnt_q   <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state_q <= TS_IDLE;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state_q)
          TS_IDLE: ;
          TS_ADDR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_s};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              if (sh_q[7:1] == TARGET_ADDR) begin
                sda_oe   <= 1'b1;
                rw_q     <= sh_q[0];
                rd_first <= sh_q[0];
                state_q  <= TS_ADDR_ACK;
              end else begin
                state_q <= TS_IDLE;
              end
            end
          end
          TS_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                sda_oe  <= ~tx_byte[7];
                txs_q   <= {tx_byte[6:0], 1'b0};
                state_q <= TS_RBYTE;
              end else begin
                sda_oe  <= 1'b0;
                first_q <= 1'b1;
                state_q <= TS_WBYTE;
              end
            end
          end
          TS_WBYTE: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_s};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              sda_oe       <= 1'b1;
              wb_valid     <= 1'b1;
              wb_data      <= sh_q;
              wb_is_offset <= first_q;
              first_q      <= 1'b0;
              state_q      <= TS_WACK;
            end
          end
          TS_WACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              cnt_q   <= '0;
              state_q <= TS_WBYTE;
            end
          end
          TS_RBYTE: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_oe  <= 1'b0;
                state_q <= TS_RACK;
              end else begin
                sda_oe <= ~txs_q[7];
                txs_q  <= {txs_q[6:0], 1'b0};
              end
            end
          end
          TS_RACK: begin
            if (scl_rise) begin
              nack_q  <= sda_s;
              rd_next <= 1'b1;
              rd_ack  <= ~sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                state_q <= TS_IDLE;
              end else begin
                sda_oe  <= ~tx_byte[7];
                txs_q   <= {tx_byte[6:0], 1'b0};
                cnt_q   <= '0;
                state_q <= TS_RBYTE;
              end
            end
          end
          default: state_q <= TS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/page_reg_ctl.sv
module page_reg_ctl
  import paged_i2c_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int PAGE_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_valid,
  input  i2c_byte_t         wb_data,
  input  logic              wb_is_offset,
  input  logic              rd_first,
  input  logic              rd_next,
  input  logic              rd_ack,
  input  i2c_byte_t         reg_rdata,
  output i2c_byte_t         tx_byte,
  output logic [PAGE_W-1:0] reg_page,
  output i2c_byte_t         reg_offset,
  output i2c_byte_t         reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd
);
  localparam i2c_byte_t SEL_OFFSET = 8'hFF;
  localparam logic [PAGE_W:0] PAGE_LIMIT = (PAGE_W+1)'(NUM_PAGES);

  logic [PAGE_W-1:0] page_q;
  i2c_byte_t         ptr_q;
  i2c_byte_t         hold_q;
  logic              fetch_q;
  logic              cap_q;
  logic              page_ok;
  logic              addr_ok;

  assign page_ok = {1'b0, page_q} < PAGE_LIMIT;
  assign addr_ok = page_ok && (ptr_q != SEL_OFFSET);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q    <= '0;
      ptr_q     <= '0;
      hold_q    <= '0;
      fetch_q   <= 1'b0;
      cap_q     <= 1'b0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      fetch_q <= 1'b0;
      cap_q   <= reg_rd;
      if (reg_wr) begin
        ptr_q <= ptr_q + 8'd1;
      end
      if (wb_valid) begin
        if (wb_is_offset) begin
          ptr_q <= wb_data;
        end else if (ptr_q == SEL_OFFSET) begin
          page_q <= wb_data[PAGE_W-1:0];
          ptr_q  <= ptr_q + 8'd1;
        end else if (page_ok) begin
          reg_wr    <= 1'b1;
          reg_wdata <= wb_data;
        end else begin
          ptr_q <= ptr_q + 8'd1;
        end
      end
      if (rd_first) begin
        fetch_q <= 1'b1;
      end
      if (rd_next) begin
        ptr_q   <= ptr_q + 8'd1;
        fetch_q <= rd_ack;
      end
      if (fetch_q) begin
        if (addr_ok) begin
          reg_rd <= 1'b1;
        end else begin
          hold_q <= '0;
        end
      end
      if (cap_q) begin
        hold_q <= reg_rdata;
      end
    end
  end

  assign tx_byte    = hold_q;
  assign reg_page   = page_q;
  assign reg_offset = ptr_q;
endmodule

// File: rtl/paged_i2c_target.sv
module paged_i2c_target
  import paged_i2c_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h70,
  parameter int         NUM_PAGES   = 16,
  parameter int         SYNC_STAGES = 2,
  parameter int         PAGE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [PAGE_W-1:0] reg_page,
  output logic [7:0]        reg_offset,
  output logic [7:0]        reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [7:0]        reg_rdata
);
  logic      sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic      wb_valid, wb_is_offset, rd_first, rd_next, rd_ack;
  i2c_byte_t wb_data, tx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_target_fsm #(.TARGET_ADDR(TARGET_ADDR)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .sda_s        (sda_s),
    .tx_byte      (tx_byte),
    .sda_oe       (sda_oe),
    .wb_valid     (wb_valid),
    .wb_data      (wb_data),
    .wb_is_offset (wb_is_offset),
    .rd_first     (rd_first),
    .rd_next      (rd_next),
    .rd_ack       (rd_ack)
  );

  page_reg_ctl #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .wb_valid     (wb_valid),
    .wb_data      (wb_data),
    .wb_is_offset (wb_is_offset),
    .rd_first     (rd_first),
    .rd_next      (rd_next),
    .rd_ack       (rd_ack),
    .reg_rdata    (reg_rdata),
    .tx_byte      (tx_byte),
    .reg_page     (reg_page),
    .reg_offset   (reg_offset),
    .reg_wdata    (reg_wdata),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd)
  );
endmodule

// File: rtl/paged_i2c_target_chk.sv
module paged_i2c_target_chk #(
  parameter int NUM_PAGES = 16,
  parameter int PAGE_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [PAGE_W-1:0] reg_page,
  input logic [7:0]        reg_offset,
  input logic              reg_wr,
  input logic              reg_rd
);
  localparam logic [PAGE_W:0] PAGE_LIMIT = (PAGE_W+1)'(NUM_PAGES);

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst) reg_wr |=> !reg_wr); // R1
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst) reg_rd |=> !reg_rd); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(reg_wr && reg_rd)); // R1
  AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (reg_offset == $past(reg_offset) + 8'd1) && $stable(reg_page)); // R2
  AST_NO_SEL_WRITE: assert property (@(posedge clk) disable iff (rst) reg_wr |-> reg_offset != 8'hFF); // R3
  AST_STROBE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr || reg_rd) |-> ({1'b0, reg_page} < PAGE_LIMIT)); // R6
  AST_NO_SEL_READ: assert property (@(posedge clk) disable iff (rst) reg_rd |-> reg_offset != 8'hFF); // R6
  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> !scl_i); // R9
endmodule

bind paged_i2c_target paged_i2c_target_chk #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_i      (scl_i),
  .sda_oe     (sda_oe),
  .reg_page   (reg_page),
  .reg_offset (reg_offset),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd)
);

// File: tb/paged_i2c_target_tb.sv
module paged_i2c_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int NPG = 4;
  localparam logic [6:0] ADDR = 7'h70;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, reg_wr, reg_rd;
  logic [7:0] reg_page, reg_offset, reg_wdata;
  logic [7:0] reg_rdata = 8'h00;
  logic sda_line;

  logic [7:0] mem [NPG*256];
  int wr_cnt = 0;
  int rd_cnt = 0;
  int oe_viol = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] tbuf [16];
  logic [7:0] rbuf [16];
  bit all_ack;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  paged_i2c_target #(.TARGET_ADDR(ADDR), .NUM_PAGES(NPG)) u_dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_page(reg_page), .reg_offset(reg_offset), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  // register file on the bus side
  always @(posedge clk) begin
    if (reg_wr && reg_page < 8'(NPG)) begin
      mem[{reg_page[1:0], reg_offset}] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_rd) begin
      reg_rdata <= (reg_page < 8'(NPG)) ? mem[{reg_page[1:0], reg_offset}] : 8'hEE;
      rd_cnt <= rd_cnt + 1;
    end
  end

  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && sda_oe && !oe_prev && m_scl) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0;
  endtask

  task automatic i2c_stop();
    wq(); m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
  endtask

  task automatic bit_out(input logic b);
    wq(); m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_line; wq(); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(ack ? 1'b0 : 1'b1);
  endtask

  // write transaction: address byte then tbuf[0..n-1]
  task automatic wr_txn(input logic [6:0] a, input int n);
    bit ack;
    all_ack = 1;
    i2c_start();
    send_byte({a, 1'b0}, ack); all_ack &= ack;
    for (int i = 0; i < n; i++) begin send_byte(tbuf[i], ack); all_ack &= ack; end
    i2c_stop();
  endtask

  // offset write, repeated start, n reads (last one NACKed)
  task automatic rd_txn(input logic [7:0] off, input int n);
    bit ack;
    all_ack = 1;
    i2c_start();
    send_byte({ADDR, 1'b0}, ack); all_ack &= ack;
    send_byte(off, ack); all_ack &= ack;
    i2c_start();
    send_byte({ADDR, 1'b1}, ack); all_ack &= ack;
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    i2c_stop();
  endtask

  task automatic set_page(input logic [7:0] p);
    tbuf[0] = 8'hFF; tbuf[1] = p;
    wr_txn(ADDR, 2);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R10 sda_oe", int'(sda_oe), 0);
    chk(reg_wr == 1'b0 && reg_rd == 1'b0, "R10 strobes", int'({reg_wr, reg_rd}), 0);
    chk(reg_page == 8'h00, "R10/R4 page", int'(reg_page), 0);
    chk(reg_offset == 8'h00, "R10 offset", int'(reg_offset), 0);
  endtask

  task automatic t_basic_write();
    int w0 = wr_cnt;
    tbuf[0] = 8'h10; tbuf[1] = 8'hA5; tbuf[2] = 8'h5A; tbuf[3] = 8'hC3;
    wr_txn(ADDR, 4);
    chk(all_ack, "R8 write acks", int'(all_ack), 1);
    chk(mem[16'h0010] == 8'hA5, "R1 msb byte", int'(mem[16'h0010]), 'hA5);
    chk(mem[16'h0011] == 8'h5A, "R2 next offset", int'(mem[16'h0011]), 'h5A);
    chk(mem[16'h0012] == 8'hC3, "R2 third offset", int'(mem[16'h0012]), 'hC3);
    chk(wr_cnt - w0 == 3, "R1 strobe count", wr_cnt - w0, 3);
  endtask

  task automatic t_page_select();
    int w0 = wr_cnt;
    tbuf[0] = 8'hFF; tbuf[1] = 8'h02; tbuf[2] = 8'h11; tbuf[3] = 8'h22;
    wr_txn(ADDR, 4);
    chk(mem[16'h0200] == 8'h11, "R3 new page offset 0", int'(mem[16'h0200]), 'h11);
    chk(mem[16'h0201] == 8'h22, "R3 new page offset 1", int'(mem[16'h0201]), 'h22);
    chk(wr_cnt - w0 == 2, "R3 no strobe for page byte", wr_cnt - w0, 2);
    chk(reg_page == 8'h02, "R3 page port", int'(reg_page), 2);
  endtask

  task automatic t_page_persist();
    tbuf[0] = 8'h40; tbuf[1] = 8'h77;
    wr_txn(ADDR, 2);
    chk(mem[16'h0240] == 8'h77, "R4 page kept", int'(mem[16'h0240]), 'h77);
    chk(mem[16'h0040] == 8'h00, "R4 page 0 untouched", int'(mem[16'h0040]), 0);
  endtask

  task automatic t_read_burst();
    set_page(8'h00);
    rd_txn(8'h10, 3);
    chk(all_ack, "R5 read acks", int'(all_ack), 1);
    chk(rbuf[0] == 8'hA5, "R5 byte 0", int'(rbuf[0]), 'hA5);
    chk(rbuf[1] == 8'h5A, "R5 byte 1", int'(rbuf[1]), 'h5A);
    chk(rbuf[2] == 8'hC3, "R5 byte 2", int'(rbuf[2]), 'hC3);
  endtask

  task automatic t_read_wrap();
    mem[16'h02FE] = 8'h3C;
    set_page(8'h02);
    rd_txn(8'hFE, 3);
    chk(rbuf[0] == 8'h3C, "R2 wrap 0xFE", int'(rbuf[0]), 'h3C);
    chk(rbuf[1] == 8'h00, "R6 selector reads zero", int'(rbuf[1]), 0);
    chk(rbuf[2] == 8'h11, "R2 wrap to 0x00 same page", int'(rbuf[2]), 'h11);
  endtask

  task automatic t_unimpl();
    int w0, r0;
    w0 = wr_cnt;
    tbuf[0] = 8'hFF; tbuf[1] = 8'h06; tbuf[2] = 8'h99;
    wr_txn(ADDR, 3);
    chk(all_ack, "R6 unimpl write acked", int'(all_ack), 1);
    chk(wr_cnt == w0, "R6 no write strobe", wr_cnt - w0, 0);
    r0 = rd_cnt;
    rd_txn(8'h00, 2);
    chk(all_ack, "R6 unimpl read acked", int'(all_ack), 1);
    chk(rbuf[0] == 8'h00 && rbuf[1] == 8'h00, "R6 zero data", int'({rbuf[0], rbuf[1]}), 0);
    chk(rd_cnt == r0, "R6 no read strobe", rd_cnt - r0, 0);
    set_page(8'h00);
  endtask

  task automatic t_wrong_addr();
    int w0 = wr_cnt;
    bit ack;
    i2c_start();
    send_byte({7'h21, 1'b0}, ack);
    chk(!ack, "R7 no ack", int'(ack), 0);
    send_byte(8'h05, ack);
    chk(!ack, "R7 data not acked", int'(ack), 0);
    send_byte(8'h99, ack);
    i2c_stop();
    chk(wr_cnt == w0, "R7 no strobe", wr_cnt - w0, 0);
    chk(mem[16'h0005] == 8'h00, "R7 register untouched", int'(mem[16'h0005]), 0);
  endtask

  task automatic t_nack_end();
    bit ack;
    logic [7:0] b;
    i2c_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h11, ack);
    i2c_start();
    send_byte({ADDR, 1'b1}, ack);
    recv_byte(b, 1'b0);
    chk(b == 8'h5A, "R8 byte before nack", int'(b), 'h5A);
    recv_byte(b, 1'b0);
    chk(b == 8'hFF, "R8 released after nack", int'(b), 'hFF);
    i2c_stop();
  endtask

  initial begin
    for (int i = 0; i < NPG*256; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic_write();
    t_page_select();
    t_page_persist();
    t_read_burst();
    t_read_wrap();
    t_unimpl();
    t_wrong_addr();
    t_nack_end();
    chk(oe_viol == 0, "R9 drive only while SCL low", oe_viol, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule